// File: doc/BRIEF.md
# APB Compare Delay Timer

This block is a slave peripheral on an APB3 bus. It gives software a simple delay timer. A free-running binary prescaler divides the bus clock. The rising edge of the prescaler's top bit is a slow tick. With an 18-bit prescaler and a 25 MHz bus clock, the tick runs at about 95 Hz. Each tick advances a 16-bit counter.

A comparator watches the counter against a compare value that software programs. When the two match, the comparator raises a sticky match flag. From then on the counter holds its value, so the match can never be passed by wrapping around.

To wait, software first writes the compare value. It then pulses the clear bit high and low again, and polls the match flag. All logic runs on the bus clock alone. The tick is a clock enable, not a derived clock. Read data is captured in the setup phase, so a transfer never needs a wait state.

Top module: `apb_cmp_timer`

## Requirements
- R1: A register is written on a PCLK rising edge only when PSEL, PWRITE and PENABLE are all high. A cycle with PSEL and PWRITE high but PENABLE low changes nothing.
- R2: Read data is captured into PRDATA on every edge where PSEL is high and PWRITE is low, whether or not PENABLE is high. The addressed value is therefore valid on PRDATA during the access phase.
- R3: PREADY is always 1 and PSLVERR is always 0.
- R4: Driving PRESETN low clears PRDATA, the compare value, the clear bit, the counter and the match flag to zero. With compare 0 and counter 0, the match flag then rises on the first clock edge after reset is released, and a read returns 1.
- R5: The prescaler is a PRE_W-bit binary counter advanced every PCLK cycle. The counter advances by exactly 1 on the cycle after each 0-to-1 transition of the prescaler's top bit, which is once per 2^PRE_W cycles.
- R6: When the counter equals the compare value, the match flag is set on the next edge. It stays 1 until the clear bit is written to 1, including after the compare value is rewritten.
- R7: Writing 1 to bit 0 at offset 0x08 clears the counter and the match flag, and keeps them at zero for as long as the bit stays 1, even if the compare value is 0. Counting restarts from 0 once 0 is written.
- R8: The register map uses PADDR bits 7:0, with bits above 7 required to be zero.
  - Offset 0x00 is the compare register. It is write-only and takes PWDATA bits 15:0.
  - Offset 0x04 returns the match flag in bit 0, with all other bits 0. It is read-only.
  - Offset 0x08 is the clear bit, write-only, taken from PWDATA bit 0.
  - Reads of 0x00, 0x08 and any other offset return 0.
- R9: While the match flag is 1 and the clear bit is 0, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock; the only clock of the block |
| presetn | input | 1 | Active-low bus reset, synchronous to pclk |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (12) | Byte address within the slave window |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Registered read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |

## Verification
The counter cannot be read, so its progress can only be seen through the moment the match flag rises. The bench shrinks the prescaler to 4 bits. It then reads the flag in windows that bracket the earliest and latest possible match cycle for a given compare value, whatever the phase of the free-running prescaler. The hardest case to reach is a write attempt with PENABLE held low. The bench drives a setup-only cycle to the clear bit while the flag is set, then reads the flag back to show it survived. Setup-phase capture is shown by reading a zero-valued offset directly before the flag, so a stale capture would be exposed.

// File: rtl/apb_cmp_timer_pkg.sv
package apb_cmp_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OFS_CMP  = 8'h00;
  localparam logic [7:0] OFS_FLAG = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;

  function automatic reg_sel_e decode_offset(input logic [7:0] ofs, input logic hi_zero);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (hi_zero) begin
      case (ofs)
        OFS_CMP:  sel = SEL_CMP;
        OFS_FLAG: sel = SEL_FLAG;
        OFS_CLR:  sel = SEL_CLR;
        default:  sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

  function automatic logic is_write_access(input logic sel, input logic en, input logic wr);
    return sel & en & wr;
  endfunction

  function automatic logic is_read_capture(input logic sel, input logic wr);
    return sel & ~wr;
  endfunction

endpackage

// File: rtl/acmt_prescaler.sv
module acmt_prescaler #(
  parameter int PRE_W = 18
) (
  input  logic pclk,
  input  logic presetn,
  output logic tick
);
  localparam int MSB = PRE_W - 1;

  logic [PRE_W-1:0] pre_q;
  logic             msb_q;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      pre_q <= '0;
      msb_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      msb_q <= pre_q[MSB];
    end
  end

  assign tick = pre_q[MSB] & ~msb_q;

  assert_tick_single_R5: assert property (@(posedge pclk) disable iff (!presetn)
    tick |=> !tick);

endmodule

// File: rtl/acmt_apb_regs.sv
module acmt_apb_regs
  import apb_cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              match_flag,
  output logic [DATA_W-1:0] prdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              clr_bit
);
  reg_sel_e          sel;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] prdata_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              clr_q;
  logic              unused_wdata;

  assign sel     = decode_offset(paddr[7:0], paddr[ADDR_W-1:8] == '0);
  assign wr_fire = is_write_access(psel, penable, pwrite);
  assign rd_fire = is_read_capture(psel, pwrite);
  assign unused_wdata = ^pwdata[DATA_W-1:CNT_W];

  always_comb begin
    rd_word = '0;
    if (sel == SEL_FLAG) rd_word[0] = match_flag;
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      cmp_q    <= '0;
      clr_q    <= 1'b0;
      prdata_q <= '0;
    end else begin
      if (wr_fire && sel == SEL_CMP) cmp_q <= pwdata[CNT_W-1:0];
      if (wr_fire && sel == SEL_CLR) clr_q <= pwdata[0];
      if (rd_fire) prdata_q <= rd_word;
    end
  end

  assign prdata  = prdata_q;
  assign cmp_val = cmp_q;
  assign clr_bit = clr_q;

  assert_write_needs_access_R1: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite) |=> ($stable(cmp_val) && $stable(clr_bit)));

  assert_setup_capture_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && !penable && paddr == ADDR_W'(OFS_FLAG)) |=>
      prdata == DATA_W'($past(match_flag)));

  assert_wo_reads_zero_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr != ADDR_W'(OFS_FLAG)) |=> prdata == '0);

endmodule

// File: rtl/acmt_counter.sv
module acmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             tick,
  input  logic             clr_bit,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match_flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             hit;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign hit = (cnt_q == cmp_val);

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_bit) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (flag_q) begin
      cnt_q  <= cnt_q;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= step(cnt_q);
    end
  end

  assign match_flag = flag_q;

  assert_step_by_one_R5: assert property (@(posedge pclk) disable iff (!presetn)
    !clr_bit |=> (cnt_q == $past(cnt_q) || cnt_q == step($past(cnt_q))));

  assert_match_sets_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (!clr_bit && hit) |=> match_flag);

  assert_sticky_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (match_flag && !clr_bit) |=> match_flag);

  assert_clear_R7: assert property (@(posedge pclk) disable iff (!presetn)
    clr_bit |=> (cnt_q == '0 && !match_flag));

  assert_hold_on_match_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (match_flag && !clr_bit) |=> $stable(cnt_q));

endmodule

// File: rtl/apb_cmp_timer.sv
module apb_cmp_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 18
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);
  logic             tick;
  logic             clr_bit;
  logic             match_flag;
  logic [CNT_W-1:0] cmp_val;

  acmt_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .match_flag(match_flag),
    .prdata(prdata), .cmp_val(cmp_val), .clr_bit(clr_bit)
  );

  acmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .pclk(pclk), .presetn(presetn), .tick(tick)
  );

  acmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .pclk(pclk), .presetn(presetn), .tick(tick), .clr_bit(clr_bit),
    .cmp_val(cmp_val), .match_flag(match_flag)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_flag_cleared_by_reset_R4: assert property (@(posedge pclk)
    !presetn |=> (!match_flag && prdata == '0));

endmodule

// File: tb/apb_cmp_timer_bench.sv
module apb_cmp_timer_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 4;

  logic              pclk = 1'b0;
  logic              presetn = 1'b0;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              pready;
  logic              pslverr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 pclk = ~pclk;

  apb_cmp_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(16), .PRE_W(PRE_W)) u_apb_cmp_timer (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    check("R3 handshake", {30'd0, pready, pslverr}, 32'd2);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    d = prdata;
    check("R3 handshake", {30'd0, pready, pslverr}, 32'd2);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    check("R4 prdata after reset", prdata, 32'd0);
    bus_read(12'h004, d);
    check("R4 flag set from compare 0 after reset", d, 32'd1);
  endtask

  task automatic t_addr_map;
    logic [DATA_W-1:0] d;
    bus_write(12'h000, 32'hABCD_1234);
    bus_read(12'h000, d);
    check("R8 compare reads 0", d, 32'd0);
    bus_read(12'h008, d);
    check("R8 clear reads 0", d, 32'd0);
    bus_read(12'h00C, d);
    check("R8 unmapped reads 0", d, 32'd0);
    bus_read(12'h104, d);
    check("R8 high address bits not decoded as flag", d, 32'd0);
  endtask

  task automatic t_setup_capture;
    logic [DATA_W-1:0] d;
    bus_read(12'h000, d);
    bus_read(12'h004, d);
    check("R2 flag valid in access phase", d, 32'd1);
  endtask

  task automatic t_setup_only_ignored;
    logic [DATA_W-1:0] d;
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h008; pwdata = 32'd1;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    idle(2);
    bus_read(12'h004, d);
    check("R1 setup-only write to clear ignored", d, 32'd1);
  endtask

  task automatic t_clear_hold;
    logic [DATA_W-1:0] d;
    bus_write(12'h008, 32'd1);
    bus_read(12'h004, d);
    check("R7 clear drops flag", d, 32'd0);
    bus_write(12'h000, 32'd0);
    idle(100);
    bus_read(12'h004, d);
    check("R7 held clear beats compare 0", d, 32'd0);
  endtask

  task automatic t_count_window;
    logic [DATA_W-1:0] d;
    bus_write(12'h000, 32'd4);
    bus_write(12'h008, 32'd0);
    idle(20);
    bus_read(12'h004, d);
    check("R5 no match before 3 ticks", d, 32'd0);
    idle(80);
    bus_read(12'h004, d);
    check("R6 match after 4 ticks", d, 32'd1);
  endtask

  task automatic t_sticky;
    logic [DATA_W-1:0] d;
    bus_write(12'h000, 32'h0000_0100);
    idle(50);
    bus_read(12'h004, d);
    check("R6 flag sticky after compare rewrite", d, 32'd1);
    bus_write(12'h000, 32'd7);
    idle(150);
    bus_read(12'h004, d);
    check("R9 counter held at match, flag stays", d, 32'd1);
  endtask

  task automatic t_resume;
    logic [DATA_W-1:0] d;
    bus_write(12'h000, 32'd2);
    bus_write(12'h008, 32'd1);
    bus_write(12'h008, 32'd0);
    idle(8);
    bus_read(12'h004, d);
    check("R7 restart from 0, no early match", d, 32'd0);
    idle(60);
    bus_read(12'h004, d);
    check("R7 counting resumed to match", d, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_addr_map();
    t_setup_capture();
    t_setup_only_ignored();
    t_clear_hold();
    t_count_window();
    t_sticky();
    t_resume();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule